// File: doc/BRIEF.md
# Operational Mode Request Controller

This block sits between software and the power-management unit of a low-power subsystem. Software writes a 2-bit request naming one of four operational modes. The block checks that the request is a single legal step from the current mode. It then holds the request open toward the power-management unit until that unit signals ready, and only then updates the acknowledged mode. Software must treat the acknowledged mode as the mode the subsystem is actually in.

From the acknowledged mode and an external wakeup flag, the block forms an effective mode. The effective mode drives the supply-state request and the clock-source selection. The two powerdown modes differ only in where the wakeup flag sends them. One goes to active while the flag is set; the other goes to low-power. Requests that break the stepping rules are dropped and leave a sticky error flag, which software clears with a write-one pulse.

Top module: `opm_ctrl`

## Requirements
- R1: After reset the acknowledged mode is 0 (active), `busy` and `err` are 0, `supply_active` is 1 and `clk_sel` is 0.
- R2: Mode codes are 0 = active, 1 = low-power, 2 = powerdown-wake-to-active, 3 = powerdown-wake-to-low-power, and they form the chain 2 – 0 – 1 – 3. An accepted request to a neighbouring code raises `busy` and `pm_req` from the cycle after the write until acknowledgement.
- R3: A request to a code that is not a neighbour of the acknowledged mode on the chain is ignored and sets `err`.
- R4: A request written while `busy` is 1 is ignored, leaves the pending target unchanged, and sets `err`.
- R5: `ack_mode` changes only in the cycle after one in which `busy` and `pm_ready` are both 1. It then takes the pending target, and `busy` falls in the same cycle.
- R6: `err` stays set until a cycle with `err_clr` high and no new violation. A violation in the same cycle as a clear leaves `err` set.
- R7: `supply_active` is 1 exactly when the effective mode is active (0).
- R8: With acknowledged mode 2 and `wake` high, the effective mode is active. With acknowledged mode 3 and `wake` high, it is low-power. Both take effect in the same cycle as `wake`.
- R9: With acknowledged mode 0 or 1, `wake` has no effect on any output.
- R10: `clk_sel` is 0 (normal source) for effective active, 1 (medium-frequency clock) for effective low-power, and 2 (powerdown source) for either powerdown mode.
- R11: A request equal to the acknowledged mode while idle is a no-op. It raises neither `busy` nor `err`.
- R12: While `busy` is 1, `pm_tgt_active` is 1 exactly when the pending target is mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Software write strobe for a mode request |
| req_mode | input | 2 | Requested mode code |
| err_clr | input | 1 | Write-one pulse clearing the error flag |
| wake | input | 1 | External wakeup flag |
| pm_ready | input | 1 | Power-management unit ready for the pending supply state |
| pm_req | output | 1 | Handshake request toward the power-management unit |
| pm_tgt_active | output | 1 | Supply state the pending target needs (1 = active) |
| ack_mode | output | 2 | Acknowledged (current) mode |
| eff_mode | output | 2 | Effective mode after wakeup override |
| busy | output | 1 | Request pending, not yet acknowledged |
| err | output | 1 | Sticky illegal-request flag |
| supply_active | output | 1 | Supply-state request, 1 = active, 0 = powerdown |
| clk_sel | output | 2 | Clock-source selection |

## Verification
The main internal state is the pending target. A wrong target either leaves `busy` high when it should be low or shows through `pm_tgt_active` in the cycle after the write. The acknowledged mode then lands on a wrong code one cycle after `pm_ready`. A broken override or mapping is visible on `eff_mode`, `supply_active` and `clk_sel` in the same cycle that `wake` or the acknowledged mode changes. A wrong legality decision flips `err` in the cycle after the write.

// File: rtl/opm_pkg.sv
package opm_pkg;

    typedef enum logic [1:0] {
        M_ACT = 2'd0,
        M_LOW = 2'd1,
        M_PDA = 2'd2,
        M_PDL = 2'd3
    } mode_t;

    typedef enum logic [1:0] {
        CS_NORM = 2'd0,
        CS_MF   = 2'd1,
        CS_PD   = 2'd2
    } clksrc_t;

    typedef struct packed {
        mode_t tgt;
        mode_t ack;
        logic  err;
    } ctrl_state_t;

    // Position of a mode on the linear chain used for step legality.
    function automatic logic [2:0] chain_pos(mode_t m);
        case (m)
            M_PDA:   return 3'd0;
            M_ACT:   return 3'd1;
            M_LOW:   return 3'd2;
            default: return 3'd3;
        endcase
    endfunction

    function automatic logic is_neighbour(mode_t a, mode_t b);
        logic [2:0] pa;
        logic [2:0] pb;
        pa = chain_pos(a);
        pb = chain_pos(b);
        return (pa == pb + 3'd1) || (pb == pa + 3'd1);
    endfunction

endpackage

// File: rtl/opm_step_check.sv
module opm_step_check
    import opm_pkg::*;
(
    input  mode_t cur_mode,
    input  mode_t new_mode,
    input  logic  wr,
    input  logic  pending,
    output logic  take,
    output logic  violation
);
    logic same_mode;
    logic step_ok;

    always_comb begin
        same_mode = (new_mode == cur_mode);
        step_ok   = is_neighbour(cur_mode, new_mode);
        take      = wr && !pending && step_ok;
        violation = wr && !(step_ok || same_mode) && !pending
                 || wr && pending;
    end
endmodule

// File: rtl/opm_wake_override.sv
module opm_wake_override
    import opm_pkg::*;
#(
    parameter int CS_W = 2
) (
    input  mode_t           ack_mode,
    input  logic            wake,
    output mode_t           eff_mode,
    output logic            supply_active,
    output logic [CS_W-1:0] clk_sel
);
    always_comb begin
        eff_mode = ack_mode;
        if (wake && ack_mode == M_PDA) eff_mode = M_ACT;
        if (wake && ack_mode == M_PDL) eff_mode = M_LOW;

        supply_active = (eff_mode == M_ACT);

        case (eff_mode)
            M_ACT:   clk_sel = CS_W'(CS_NORM);
            M_LOW:   clk_sel = CS_W'(CS_MF);
            default: clk_sel = CS_W'(CS_PD);
        endcase
    end
endmodule

// File: rtl/opm_ctrl.sv
module opm_ctrl
    import opm_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic              err_clr,
    input  logic              wake,
    input  logic              pm_ready,
    output logic              pm_req,
    output logic              pm_tgt_active,
    output logic [MODE_W-1:0] ack_mode,
    output logic [MODE_W-1:0] eff_mode,
    output logic              busy,
    output logic              err,
    output logic              supply_active,
    output logic [CS_W-1:0]   clk_sel
);
    ctrl_state_t st_d, st_q;
    logic        take;
    logic        violation;
    logic        pending;
    mode_t       eff_m;

    assign pending = (st_q.tgt != st_q.ack);

    opm_step_check u_check (
        .cur_mode  (st_q.ack),
        .new_mode  (mode_t'(req_mode)),
        .wr        (req_valid),
        .pending   (pending),
        .take      (take),
        .violation (violation)
    );

    opm_wake_override #(.CS_W(CS_W)) u_wake (
        .ack_mode      (st_q.ack),
        .wake          (wake),
        .eff_mode      (eff_m),
        .supply_active (supply_active),
        .clk_sel       (clk_sel)
    );

    always_comb begin
        st_d = st_q;
        if (pending && pm_ready) st_d.ack = st_q.tgt;
        if (take)                st_d.tgt = mode_t'(req_mode);
        if (violation)           st_d.err = 1'b1;
        else if (err_clr)        st_d.err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tgt <= M_ACT;
            st_q.ack <= M_ACT;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy          = pending;
    assign pm_req        = pending;
    assign pm_tgt_active = (st_q.tgt == M_ACT);
    assign ack_mode      = st_q.ack;
    assign eff_mode      = eff_m;
    assign err           = st_q.err;

    // R5
    ack_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_mode) |-> $past(pm_ready && busy));

    // R2
    ack_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ack_mode) |-> is_neighbour(mode_t'($past(ack_mode)), mode_t'(ack_mode)));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(err_clr));

    // R4
    tgt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pm_ready) |=> (busy && $stable(pm_tgt_active)));

    // R7
    active_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_mode == 2'd0) |-> (supply_active && clk_sel == '0));
endmodule

// File: tb/tb_opm_ctrl.sv
`timescale 1ns/1ps
module tb_opm_ctrl;
    localparam int PM_LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic       err_clr = 1'b0;
    logic       wake = 1'b0;
    logic       pm_ready = 1'b0;
    logic       pm_req, pm_tgt_active, busy, err, supply_active;
    logic [1:0] ack_mode, eff_mode, clk_sel;

    int checks = 0;
    int errors = 0;
    int pm_cnt = 0;
    logic done = 1'b0;

    logic [1:0] exp_tgt = 2'd0;
    logic [1:0] exp_ack = 2'd0;
    logic       exp_err = 1'b0;

    always #2.5 clk = ~clk;

    opm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .err_clr(err_clr), .wake(wake), .pm_ready(pm_ready), .pm_req(pm_req),
        .pm_tgt_active(pm_tgt_active), .ack_mode(ack_mode), .eff_mode(eff_mode),
        .busy(busy), .err(err), .supply_active(supply_active), .clk_sel(clk_sel)
    );

    function automatic int tb_pos(logic [1:0] m);
        case (m)
            2'd2: return 0;
            2'd0: return 1;
            2'd1: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic logic tb_adj(logic [1:0] a, logic [1:0] b);
        int d;
        d = tb_pos(a) - tb_pos(b);
        return (d == 1) || (d == -1);
    endfunction

    function automatic logic [1:0] tb_eff(logic [1:0] a, logic w);
        if (w && a == 2'd2) return 2'd0;
        if (w && a == 2'd3) return 2'd1;
        return a;
    endfunction

    function automatic logic [1:0] tb_clk(logic [1:0] e);
        if (e == 2'd0) return 2'd0;
        if (e == 2'd1) return 2'd1;
        return 2'd2;
    endfunction

    // Power-management partner with fixed latency.
    always @(negedge clk) begin
        if (!rst_n) begin
            pm_cnt = 0;
            pm_ready = 1'b0;
        end else if (pm_ready) begin
            pm_ready = 1'b0;
            pm_cnt = 0;
        end else if (pm_req) begin
            pm_cnt++;
            if (pm_cnt >= PM_LAT) pm_ready = 1'b1;
        end
    end

    // Reference model built from the requirements.
    always @(posedge clk) begin
        logic bz;
        logic ok;
        if (!rst_n) begin
            exp_tgt <= 2'd0;
            exp_ack <= 2'd0;
            exp_err <= 1'b0;
        end else begin
            bz = (exp_tgt != exp_ack);
            ok = 1'b1;
            if (bz && pm_ready) exp_ack <= exp_tgt;
            if (req_valid) begin
                if (bz) ok = 1'b0;
                else if (req_mode == exp_ack) ok = 1'b1;
                else if (tb_adj(exp_ack, req_mode)) exp_tgt <= req_mode;
                else ok = 1'b0;
            end
            if (!ok) exp_err <= 1'b1;
            else if (err_clr) exp_err <= 1'b0;
        end
    end

    task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [1:0] e;
        e = tb_eff(exp_ack, wake);
        chk("R5 ack_mode", ack_mode, exp_ack);
        chk("R2 busy", {1'b0, busy}, {1'b0, exp_tgt != exp_ack});
        chk("R2 pm_req", {1'b0, pm_req}, {1'b0, exp_tgt != exp_ack});
        chk("R6 err", {1'b0, err}, {1'b0, exp_err});
        chk((exp_ack >= 2'd2) ? "R8 eff_mode" : "R9 eff_mode", eff_mode, e);
        chk("R7 supply_active", {1'b0, supply_active}, {1'b0, e == 2'd0});
        chk("R10 clk_sel", clk_sel, tb_clk(e));
        if (exp_tgt != exp_ack)
            chk("R12 pm_tgt_active", {1'b0, pm_tgt_active}, {1'b0, exp_tgt == 2'd0});
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
        #1;
        req_valid = 1'b0;
        err_clr = 1'b0;
    endtask

    task automatic request(logic [1:0] m);
        req_valid = 1'b1;
        req_mode = m;
        step();
    endtask

    task automatic settle();
        for (int i = 0; i < 40 && (busy || pm_ready); i++) step();
        step();
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 ack", ack_mode, 2'd0);
        chk("R1 busy/err", {busy, err}, 2'b00);
        chk("R1 supply/clk", {supply_active, clk_sel}, 3'b100);

        // R11 same-mode request is a no-op
        request(2'd0);
        chk("R11 busy/err", {busy, err}, 2'b00);

        // R3 skip from active to powerdown-wake-to-low-power
        request(2'd3);
        chk("R3 err set", {1'b0, err}, 2'd1);
        chk("R3 still idle", {1'b0, busy}, 2'd0);
        step(); step();
        chk("R6 err sticky", {1'b0, err}, 2'd1);
        err_clr = 1'b1; step();
        chk("R6 err cleared", {1'b0, err}, 2'd0);

        // R2 legal step, R4 write while busy
        request(2'd1);
        chk("R2 busy raised", {1'b0, busy}, 2'd1);
        chk("R12 target low-power", {1'b0, pm_tgt_active}, 2'd0);
        request(2'd3);
        chk("R4 err on busy write", {1'b0, err}, 2'd1);
        settle();
        chk("R4 ack kept first target", ack_mode, 2'd1);
        // R6 clear and violation together: set wins
        err_clr = 1'b1; request(2'd2);
        chk("R6 set wins", {1'b0, err}, 2'd1);
        err_clr = 1'b1; step();

        // R9 wake ignored in low-power
        wake = 1'b1; step();
        chk("R9 low-power with wake", eff_mode, 2'd1);
        wake = 1'b0;
        request(2'd3); settle();
        chk("R10 powerdown clock", clk_sel, 2'd2);
        wake = 1'b1; step();
        chk("R8 wake to low-power", eff_mode, 2'd1);
        chk("R7 supply stays down", {1'b0, supply_active}, 2'd0);
        wake = 1'b0;
        request(2'd1); settle();
        request(2'd0); settle();
        chk("R12 back to active", ack_mode, 2'd0);
        wake = 1'b1; step();
        chk("R9 active with wake", eff_mode, 2'd0);
        wake = 1'b0;
        request(2'd2); settle();
        wake = 1'b1; step();
        chk("R8 wake to active", eff_mode, 2'd0);
        chk("R7 supply active on wake", {1'b0, supply_active}, 2'd1);
        chk("R10 normal clock on wake", clk_sel, 2'd0);
        wake = 1'b0; step();
        chk("R8 wake released", eff_mode, 2'd2);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) wake = ~wake;
            err_clr = ($urandom_range(0, 19) == 0);
            req_valid = ($urandom_range(0, 9) < 3);
            req_mode = 2'($urandom_range(0, 3));
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule